// File: doc/BRIEF.md
# Preemptive Priority Interrupt Arbiter

This block watches a parameterised set of interrupt sources. Each source has a 4-bit priority chosen by configuration. A source is pending when its hardware line is high or when its software flag has been set. Every cycle a balanced comparison tree picks one pending source. The highest priority wins, and among equal priorities the source with the smallest index wins. The result is registered as the current winner, together with its 9-bit vector number.

A single request line to the processor is raised whenever the registered winner's priority is strictly above the current-priority register. That holds whether a more urgent source has appeared or software has just written a lower current priority.

When the processor acknowledges a raised request, the block does three things in the same cycle:
- It copies the winner's priority into the current-priority register.
- It captures the vector and priority of the acknowledged source in output registers.
- It holds those captured values until the next accepted acknowledge.

Stacking of preempted priorities and any bus register decoding are left to surrounding logic.

Top module: `prio_irq_arbiter`

## Requirements
- R1: Among pending sources, the one with the highest configured priority wins. When several share that priority, the lowest source index wins, whatever order they were asserted in.
- R2: The vector of a source equals its index, zero-extended to 9 bits (source 19 gives 9'd19).
- R3: `irq_o` is high exactly when a registered winner exists and its priority is strictly greater than `cur_prio_o`. The winner is registered from the inputs of the previous cycle, so a new request shows on `irq_o` one clock after it is presented.
- R4: A source configured with priority 0 never raises `irq_o`, even if every source is pending.
- R5: Writing `cur_prio_o` below the priority of an already pending winner raises `irq_o` right after the write takes effect.
- R6: An acknowledge accepted while `irq_o` is high has these effects:
  - It loads the winner's priority into `cur_prio_o` and `ack_prio_o`.
  - It loads the winner's vector into `ack_vec_o`.
  - `irq_o` drops in the next cycle unless a strictly higher request remains.
  - `ack_vec_o` and `ack_prio_o` then hold until the next accepted acknowledge.
- R7: `ack_i` while `irq_o` is low is ignored. `cur_prio_o`, `ack_vec_o` and `ack_prio_o` stay unchanged.
- R8: After reset, `irq_o`, `cur_prio_o`, `ack_vec_o` and `ack_prio_o` are zero and all software flags are clear.
- R9: `sw_set_i[i]` sets the software flag of source i. `sw_clr_i[i]` clears it, and set wins over clear in the same cycle. A source is pending when its hardware line or its flag is high.
- R10: When an accepted acknowledge and a current-priority write occur in the same cycle, the acknowledge takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hw_req_i | input | NUM_SRC | Level request from each hardware source |
| sw_set_i | input | NUM_SRC | Set the software flag of each source |
| sw_clr_i | input | NUM_SRC | Clear the software flag of each source |
| prio_cfg_i | input | NUM_SRC*4 | Priority of source i in bits [4i+3:4i] |
| cur_wr_i | input | 1 | Write strobe for the current priority |
| cur_wdata_i | input | 4 | Value written to the current priority |
| ack_i | input | 1 | Processor acknowledge |
| irq_o | output | 1 | Interrupt request to the processor |
| cur_prio_o | output | 4 | Current priority |
| ack_vec_o | output | 9 | Vector of the last acknowledged source |
| ack_prio_o | output | 4 | Priority of the last acknowledged source |

## Verification
The bench builds the arbiter with NUM_SRC = 20. That is not a power of two, so the tree is padded to 32 leaves and unpopulated leaves take part in every comparison. With only 20 sources, a short random run often produces equal-priority collisions, software and hardware requests on the same source, and acknowledges racing current-priority writes. Vector 19 crosses the upper boundary of the populated range, which confirms that padding never wins.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 9;

  typedef struct packed {
    logic              vld;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } cand_t;

  // keep lower-index side unless the other side is strictly more urgent
  function automatic cand_t pick(cand_t lo, cand_t hi);
    if (hi.vld && (!lo.vld || hi.prio > lo.prio)) return hi;
    return lo;
  endfunction
endpackage

// File: rtl/sw_req_bank.sv
module sw_req_bank #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] flag_o
);
  logic [NUM_SRC-1:0] flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~clr_i) | set_i;
  end

  assign flag_o = flag_q;

  assert_sw_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & $past(set_i)) == $past(set_i)));

  assert_sw_clr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((flag_o & $past(clr_i) & ~$past(set_i)) == '0));
endmodule

// File: rtl/prio_tree.sv
module prio_tree
  import prio_arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]        pend_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  output cand_t                     root_o
);
  localparam int LVL    = (NUM_SRC < 2) ? 1 : $clog2(NUM_SRC);
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES - 1;

  cand_t [NODES-1:0] node;

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < NUM_SRC) begin : g_src
      assign node[LEAVES-1+g] = '{vld:  pend_i[g],
                                  prio: prio_i[g*PRIO_W +: PRIO_W],
                                  vec:  VEC_W'(g)};
    end else begin : g_pad
      assign node[LEAVES-1+g] = '{vld: 1'b0, prio: '0, vec: VEC_W'(g)};
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    assign node[k] = pick(node[2*k+1], node[2*k+2]);
  end

  assign root_o = node[0];

  always_comb begin
    if (root_o.vld) begin
      assert_root_leaf_R1: assert (pend_i[root_o.vec] &&
                                   prio_i[root_o.vec*PRIO_W +: PRIO_W] == root_o.prio)
        else $error("root does not match its leaf");
      for (int i = 0; i < NUM_SRC; i++) begin
        assert_root_max_R1: assert (!pend_i[i] ||
          prio_i[i*PRIO_W +: PRIO_W] < root_o.prio ||
          (prio_i[i*PRIO_W +: PRIO_W] == root_o.prio && i >= int'(root_o.vec)))
          else $error("root is not the most urgent lowest index");
      end
    end
  end
endmodule

// File: rtl/arb_state.sv
module arb_state
  import prio_arb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cand_t             root_i,
  input  logic              ack_i,
  input  logic              cur_wr_i,
  input  logic [PRIO_W-1:0] cur_wdata_i,
  output logic              irq_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [PRIO_W-1:0] ack_prio_o
);
  cand_t             win_q;
  logic [PRIO_W-1:0] cur_q;
  logic [VEC_W-1:0]  avec_q;
  logic [PRIO_W-1:0] aprio_q;
  logic              take;

  assign irq_o = win_q.vld && (win_q.prio > cur_q);
  assign take  = ack_i && irq_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      cur_q   <= '0;
      avec_q  <= '0;
      aprio_q <= '0;
    end else begin
      win_q <= root_i;
      if (take) begin
        cur_q   <= win_q.prio;
        avec_q  <= win_q.vec;
        aprio_q <= win_q.prio;
      end else if (cur_wr_i) begin
        cur_q <= cur_wdata_i;
      end
    end
  end

  assign cur_prio_o = cur_q;
  assign ack_vec_o  = avec_q;
  assign ack_prio_o = aprio_q;

  assert_ack_loads_cur_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (cur_prio_o == ack_prio_o));

  assert_ack_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ack_i && irq_o) |=> ($stable(ack_vec_o) && $stable(ack_prio_o)));

  assert_ack_above_cur_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (ack_prio_o > $past(cur_prio_o)));

  assert_no_zero_ack_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> (ack_prio_o != '0));

  assert_ignored_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(ack_i && irq_o) && !cur_wr_i) |=> $stable(cur_prio_o));

  assert_wr_loads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_wr_i && !(ack_i && irq_o)) |=> (cur_prio_o == $past(cur_wdata_i)));
endmodule

// File: rtl/prio_irq_arbiter.sv
module prio_irq_arbiter
  import prio_arb_pkg::*;
#(
  parameter int NUM_SRC = 64
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_SRC-1:0]        hw_req_i,
  input  logic [NUM_SRC-1:0]        sw_set_i,
  input  logic [NUM_SRC-1:0]        sw_clr_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_cfg_i,
  input  logic                      cur_wr_i,
  input  logic [PRIO_W-1:0]         cur_wdata_i,
  input  logic                      ack_i,
  output logic                      irq_o,
  output logic [PRIO_W-1:0]         cur_prio_o,
  output logic [VEC_W-1:0]          ack_vec_o,
  output logic [PRIO_W-1:0]         ack_prio_o
);
  logic [NUM_SRC-1:0] sw_flag;
  logic [NUM_SRC-1:0] pend;
  cand_t              root;

  sw_req_bank #(.NUM_SRC(NUM_SRC)) u_sw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (sw_set_i),
    .clr_i  (sw_clr_i),
    .flag_o (sw_flag)
  );

  assign pend = hw_req_i | sw_flag;

  prio_tree #(.NUM_SRC(NUM_SRC)) u_tree (
    .pend_i (pend),
    .prio_i (prio_cfg_i),
    .root_o (root)
  );

  arb_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .root_i      (root),
    .ack_i       (ack_i),
    .cur_wr_i    (cur_wr_i),
    .cur_wdata_i (cur_wdata_i),
    .irq_o       (irq_o),
    .cur_prio_o  (cur_prio_o),
    .ack_vec_o   (ack_vec_o),
    .ack_prio_o  (ack_prio_o)
  );

  assert_vec_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |-> (int'(ack_vec_o) < NUM_SRC));
endmodule

// File: tb/prio_irq_arbiter_tb.sv
`timescale 1ns/1ps
module prio_irq_arbiter_tb;
  localparam int N = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] hw = '0, sset = '0, sclr = '0;
  logic [N*4-1:0] pcfg = '0;
  logic         wr = 1'b0, ack = 1'b0;
  logic [3:0]   wdata = '0;
  logic         irq;
  logic [3:0]   cur, aprio;
  logic [8:0]   avec;

  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  prio_irq_arbiter #(.NUM_SRC(N)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .hw_req_i(hw), .sw_set_i(sset), .sw_clr_i(sclr),
    .prio_cfg_i(pcfg), .cur_wr_i(wr), .cur_wdata_i(wdata), .ack_i(ack),
    .irq_o(irq), .cur_prio_o(cur), .ack_vec_o(avec), .ack_prio_o(aprio));

  // behavioural reference
  bit [N-1:0] m_sw;
  bit m_wv;
  int m_wp, m_wx, m_cur, m_av, m_ap;

  function automatic int pr(int i);
    return int'(pcfg[i*4 +: 4]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sw = '0; m_wv = 0; m_wp = 0; m_wx = 0; m_cur = 0; m_av = 0; m_ap = 0;
    end else begin
      bit acc, bv;
      int bp, bx;
      acc = ack && m_wv && (m_wp > m_cur);
      if (acc) begin
        m_cur = m_wp; m_av = m_wx; m_ap = m_wp;
      end else if (wr) m_cur = int'(wdata);
      bv = 0; bp = 0; bx = 0;
      for (int i = 0; i < N; i++)
        if ((hw[i] || m_sw[i]) && (!bv || pr(i) > bp)) begin
          bv = 1; bp = pr(i); bx = i;
        end
      m_wv = bv; m_wp = bp; m_wx = bx;
      for (int i = 0; i < N; i++)
        if (sset[i]) m_sw[i] = 1; else if (sclr[i]) m_sw[i] = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n) begin
      #1;
      chk("R3 irq", int'(irq), int'(m_wv && m_wp > m_cur));
      chk("R5 cur", int'(cur), m_cur);
      chk("R2 ack_vec", int'(avec), m_av);
      chk("R6 ack_prio", int'(aprio), m_ap);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1; tick(); ack = 0;
  endtask

  task automatic wr_cur(int v);
    wr = 1; wdata = 4'(v); tick(); wr = 0;
  endtask

  task automatic setp(int i, int p);
    pcfg[i*4 +: 4] = 4'(p);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(3);
    chk("R8 irq in reset", int'(irq), 0);
    rst_n = 1;
    tick();
    chk("R8 cur", int'(cur), 0);
    chk("R8 ack_vec", int'(avec), 0);
    chk("R8 ack_prio", int'(aprio), 0);

    // R4: every source pending at priority 0
    hw = '1; tick(3);
    chk("R4 zero priority irq", int'(irq), 0);
    hw = '0;

    // R1: equal priorities asserted high index first
    setp(12, 7); setp(5, 7); setp(3, 2);
    hw[12] = 1; tick();
    hw[5] = 1; hw[3] = 1; tick(2);
    chk("R3 irq raised", int'(irq), 1);
    do_ack();
    chk("R1 tie lowest index", int'(avec), 5);
    chk("R6 ack_prio", int'(aprio), 7);
    chk("R6 cur loaded", int'(cur), 7);
    chk("R6 irq drops", int'(irq), 0);

    // R5: lowering current priority re-raises
    wr_cur(3);
    chk("R5 irq after lower", int'(irq), 1);

    // R7: acknowledge ignored while irq low
    wr_cur(15);
    chk("R7 irq low", int'(irq), 0);
    do_ack();
    chk("R7 cur kept", int'(cur), 15);
    chk("R7 ack_vec kept", int'(avec), 5);

    // R10: acknowledge beats simultaneous write
    wr_cur(0);
    ack = 1; wr = 1; wdata = 4'd9; tick(); ack = 0; wr = 0;
    chk("R10 ack wins", int'(cur), 7);

    // R9: software request on top index
    hw = '0; setp(19, 9);
    sset[19] = 1; tick(); sset[19] = 0;
    tick();
    chk("R9 sw irq", int'(irq), 1);
    do_ack();
    chk("R2 vector 19", int'(avec), 19);
    sset[19] = 1; sclr[19] = 1; tick(); sset[19] = 0; sclr[19] = 0;
    wr_cur(0);
    chk("R9 set wins over clear", int'(irq), 1);
    sclr[19] = 1; tick(); sclr[19] = 0;
    tick();
    chk("R9 cleared", int'(irq), 0);

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(15) == 0)
        for (int i = 0; i < N; i++) setp(i, int'($urandom_range(15)));
      for (int i = 0; i < N; i++) begin
        hw[i]   = ($urandom_range(9) == 0);
        sset[i] = ($urandom_range(40) == 0);
        sclr[i] = ($urandom_range(20) == 0);
      end
      ack   = ($urandom_range(2) == 0);
      wr    = ($urandom_range(7) == 0);
      wdata = 4'($urandom_range(15));
      tick();
    end
    hw = '0; sset = '0; sclr = '0; ack = 0; wr = 0;
    tick(3);
    finish_run();
  end
endmodule